// File: doc/BRIEF.md
# Block-Normalised Adaptive Equaliser

A symbol-rate complex FIR equaliser for a wideband satellite receiver. It sits between timing recovery and frequency estimation, and it removes frequency-selective distortion such as cable slope and residual intersymbol interference. The filter has five complex taps. The taps adapt through a normalised gradient that is averaged over a block of L symbols. Each per-symbol gradient term is divided by the energy in the filter window, and the taps are updated once per block.

Before frame lock the block runs blind: the error is a constant-modulus term, and every valid symbol contributes to the gradient. After frame lock it runs in pilot mode: the error is taken against a known reference symbol, and only symbols flagged as pilots contribute. During initial acquisition, while the carrier offset is still uncompensated, the block can be put in pass-through. In pass-through the input reaches the output with the same two-symbol alignment that the centre tap gives, and the taps are frozen.

Two approximations keep the datapath to one cycle. The reciprocal of the window energy is replaced by a power of two. The modulus error is taken near unit modulus.

Top module: `adapt_eq`

## Requirements
- R1: Reset (synchronous, active low) sets the taps to a centre spike: tap index NTAP/2 holds 1.0 (1<<CFRAC) and every other tap holds 0. Reset also clears `out_vld`, `out_re`, `out_im` and the symbol history. With unchanged reset taps, an adapting mode outputs exactly the input from two valid symbols earlier (zero before two symbols have arrived).
- R2: `out_vld` is high in the cycle after each cycle with `in_vld` high and low otherwise. `out_re`/`out_im` hold their value while `out_vld` is low.
- R3: In adapting modes the output is sum over k of f_k·x_{n-k}, where x_n is the current input and x_{n-k} the k-th earlier valid input. Taps carry CFRAC fraction bits and samples DFRAC. The sum is shifted right arithmetically by CFRAC and saturated to DW bits.
- R4: `mode` = 0 (pass-through) or 3 (reserved, treated as pass-through) outputs the input from two valid symbols earlier. It freezes the taps and discards any partial gradient block.
- R5: `mode` = 1 (blind): every valid symbol adds the term −conj(x)·e/‖x‖², with e = y·(|y|²−1)/2 standing in for y·(1−1/|y|). On every L-th such symbol (L = 2^BLK_LOG2) the taps move by μ times the block average. The output of that L-th symbol still uses the old taps.
- R6: `mode` = 2 (pilot): the term uses e = y − p, with p = (`pil_re`, `pil_im`). Only valid symbols with `pil_vld` high add a term. Symbols with `pil_vld` low never change the taps, whatever their reference value.
- R7: A change of `mode` discards the partial block. A block needs L fresh contributing symbols in the new mode before the first update.
- R8: Normalisation uses 2^k in place of ‖x‖²+EPS, where k is the index of the leading one of that sum. EPS keeps the divisor non-zero.
- R9: The step size is μ = `mu`/2^MUW. `mu` must be non-zero whenever an adapting mode sees a valid symbol, so 0 < μ < 1.
- R10: Given QPSK through a three-tap channel and an aligned pilot reference, pilot-mode adaptation brings the mean squared error below 0.02. The unequalised level is 0.0625.
- R11: Given the same QPSK channel, blind adaptation reduces the mean modulus dispersion ||y|²−1| to below half of its value at the start of adaptation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Input symbol valid |
| in_re | input | DW | Input symbol, real part (signed, DFRAC fraction bits) |
| in_im | input | DW | Input symbol, imaginary part |
| pil_vld | input | 1 | Current symbol is a pilot with a known reference |
| pil_re | input | DW | Pilot reference, real part |
| pil_im | input | DW | Pilot reference, imaginary part |
| mode | input | 2 | 0 pass-through, 1 blind, 2 pilot, 3 pass-through |
| mu | input | MUW | Step size code, μ = mu/2^MUW |
| out_vld | output | 1 | Output symbol valid |
| out_re | output | DW | Equalised symbol, real part |
| out_im | output | DW | Equalised symbol, imaginary part |

## Verification
Full-scale random samples in pass-through show that the path delays by exactly two symbols and saturates nothing. The same two-symbol equality in blind and pilot mode, just short of a block or with the pilot flag held low under random references, tells a correct block count, flag gating and partial-block discard apart from an update that fires early. The first symbol after a full block must differ from the delayed input, which shows that the update lands after the L-th output and not before. Long runs of QPSK through a channel with one pre-cursor and one post-cursor show convergence: blind mode is judged by modulus dispersion and pilot mode by squared error against the aligned reference, so a wrong gradient sign or a wrong normalisation shows as divergence.

// File: rtl/eqz_pkg.sv
// Shared definitions for the adaptive equaliser.
// Assumes: mode encodings are fixed by the brief; lead_one works on up to 64 bits.
package eqz_pkg;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_BLIND  = 2'd1,
        MODE_PILOT  = 2'd2,
        MODE_RSVD   = 2'd3
    } eq_mode_e;

    // Index of the most significant set bit (0 when v is zero).
    function automatic logic [5:0] lead_one(input logic [63:0] v);
        logic [5:0] r;
        r = '0;
        for (int i = 0; i < 64; i++) begin
            if (v[i]) r = 6'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/eqz_fir.sv
// Complex FIR sum of NT taps over the current window.
// Assumes: taps have CFRAC fraction bits; the result is rescaled to sample format and saturated.
module eqz_fir #(
    parameter int NT    = 5,
    parameter int DW    = 16,
    parameter int CW    = 20,
    parameter int CFRAC = 16
) (
    input  logic signed [DW-1:0] win_re [NT],
    input  logic signed [DW-1:0] win_im [NT],
    input  logic signed [CW-1:0] tap_re [NT],
    input  logic signed [CW-1:0] tap_im [NT],
    output logic signed [DW-1:0] y_re,
    output logic signed [DW-1:0] y_im
);
    localparam int PW = DW + CW;
    localparam int SW = PW + $clog2(NT) + 1;
    localparam logic signed [SW-1:0] YMAX = SW'((1 << (DW-1)) - 1);
    localparam logic signed [SW-1:0] YMIN = ~YMAX;

    logic signed [PW-1:0] p_rr [NT], p_ii [NT], p_ri [NT], p_ir [NT];
    logic signed [SW-1:0] sum_re, sum_im;

    function automatic logic signed [DW-1:0] sat(input logic signed [SW-1:0] v);
        if (v > YMAX) return DW'(YMAX);
        if (v < YMIN) return DW'(YMIN);
        return DW'(v);
    endfunction

    for (genvar k = 0; k < NT; k++) begin : g_mul
        assign p_rr[k] = PW'(tap_re[k]) * PW'(win_re[k]);
        assign p_ii[k] = PW'(tap_im[k]) * PW'(win_im[k]);
        assign p_ri[k] = PW'(tap_re[k]) * PW'(win_im[k]);
        assign p_ir[k] = PW'(tap_im[k]) * PW'(win_re[k]);
    end

    // Accumulate the complex products of all taps.
    always_comb begin
        sum_re = '0;
        sum_im = '0;
        for (int k = 0; k < NT; k++) begin
            sum_re = sum_re + SW'(p_rr[k]) - SW'(p_ii[k]);
            sum_im = sum_im + SW'(p_ri[k]) + SW'(p_ir[k]);
        end
    end

    assign y_re = sat(sum_re >>> CFRAC);
    assign y_im = sat(sum_im >>> CFRAC);

endmodule

// File: rtl/eqz_grad.sv
// Per-symbol normalised gradient terms, one per tap.
// Error is the near-unit modulus term in blind mode, y - p otherwise.
// Assumes: energy normalisation by a power of two (leading one of energy+EPS).
module eqz_grad import eqz_pkg::*; #(
    parameter int NT    = 5,
    parameter int DW    = 16,
    parameter int DFRAC = 12,
    parameter int CFRAC = 16,
    parameter int EPS   = 65536,
    parameter int ERW   = 18,
    parameter int GW    = 52
) (
    input  logic                 blind,
    input  logic signed [DW-1:0] y_re,
    input  logic signed [DW-1:0] y_im,
    input  logic signed [DW-1:0] ref_re,
    input  logic signed [DW-1:0] ref_im,
    input  logic signed [DW-1:0] win_re [NT],
    input  logic signed [DW-1:0] win_im [NT],
    output logic signed [GW-1:0] term_re [NT],
    output logic signed [GW-1:0] term_im [NT]
);
    localparam int EW = 2*DW + $clog2(NT) + 1;
    localparam int QW = DW + ERW;
    localparam int PW = DW + ERW + 1;
    localparam logic signed [QW-1:0] ONE_Q = QW'(1 << DFRAC);
    localparam logic signed [QW-1:0] EMAX  = QW'((1 << (ERW-1)) - 1);
    localparam logic signed [QW-1:0] EMIN  = ~EMAX;

    logic signed [2*DW-1:0] sq_re [NT], sq_im [NT];
    logic signed [EW-1:0]   energy;
    logic [5:0]             nshift;
    logic signed [QW-1:0]   mag2, mdev, cm_re, cm_im;
    logic signed [ERW-1:0]  mcl, err_re, err_im;

    function automatic logic signed [ERW-1:0] clip(input logic signed [QW-1:0] v);
        if (v > EMAX) return ERW'(EMAX);
        if (v < EMIN) return ERW'(EMIN);
        return ERW'(v);
    endfunction

    for (genvar k = 0; k < NT; k++) begin : g_sq
        assign sq_re[k] = (2*DW)'(win_re[k]) * (2*DW)'(win_re[k]);
        assign sq_im[k] = (2*DW)'(win_im[k]) * (2*DW)'(win_im[k]);
    end

    // Window energy plus epsilon.
    always_comb begin
        energy = EW'(EPS);
        for (int k = 0; k < NT; k++) begin
            energy = energy + EW'(sq_re[k]) + EW'(sq_im[k]);
        end
    end

    assign nshift = lead_one(64'(energy));

    // Error selection: modulus deviation times y, or difference to the reference.
    always_comb begin
        mag2   = QW'(y_re) * QW'(y_re) + QW'(y_im) * QW'(y_im);
        mdev   = ((mag2 >>> DFRAC) - ONE_Q) >>> 1;
        mcl    = clip(mdev);
        cm_re  = (QW'(y_re) * QW'(mcl)) >>> DFRAC;
        cm_im  = (QW'(y_im) * QW'(mcl)) >>> DFRAC;
        err_re = blind ? clip(cm_re) : clip(QW'(y_re) - QW'(ref_re));
        err_im = blind ? clip(cm_im) : clip(QW'(y_im) - QW'(ref_im));
    end

    for (genvar k = 0; k < NT; k++) begin : g_term
        logic signed [PW-1:0] p_re, p_im;
        assign p_re = PW'(win_re[k]) * PW'(err_re) + PW'(win_im[k]) * PW'(err_im);
        assign p_im = PW'(win_re[k]) * PW'(err_im) - PW'(win_im[k]) * PW'(err_re);
        assign term_re[k] = (GW'(p_re) <<< CFRAC) >>> nshift;
        assign term_im[k] = (GW'(p_im) <<< CFRAC) >>> nshift;
    end

endmodule

// File: rtl/eqz_taps.sv
// Tap registers with block accumulation: sums L terms, then steps taps by mu times the mean.
// Assumes: clr has priority over acc_en; the L-th term updates taps at the same edge.
module eqz_taps #(
    parameter int NT       = 5,
    parameter int CW       = 20,
    parameter int CFRAC    = 16,
    parameter int GW       = 52,
    parameter int MUW      = 8,
    parameter int BLK_LOG2 = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 acc_en,
    input  logic [MUW-1:0]       mu,
    input  logic signed [GW-1:0] term_re [NT],
    input  logic signed [GW-1:0] term_im [NT],
    output logic signed [CW-1:0] tap_re [NT],
    output logic signed [CW-1:0] tap_im [NT]
);
    localparam int BLK = 1 << BLK_LOG2;
    localparam int AW  = GW + BLK_LOG2;
    localparam int MW  = AW + MUW + 1;
    localparam int CTR = NT / 2;
    localparam logic signed [MW-1:0] TMAX  = MW'((1 << (CW-1)) - 1);
    localparam logic signed [MW-1:0] TMIN  = ~TMAX;
    localparam logic signed [CW-1:0] ONE_C = CW'(1 << CFRAC);

    logic [BLK_LOG2-1:0] cnt;
    logic                fire;

    function automatic logic signed [CW-1:0] satc(input logic signed [MW-1:0] v);
        if (v > TMAX) return CW'(TMAX);
        if (v < TMIN) return CW'(TMIN);
        return CW'(v);
    endfunction

    assign fire = acc_en && !clr && (cnt == BLK_LOG2'(BLK - 1));

    // Count contributing symbols within the current block.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (acc_en)   cnt <= cnt + BLK_LOG2'(1);
    end

    for (genvar k = 0; k < NT; k++) begin : g_tap
        logic signed [AW-1:0] acc_re, acc_im, sum_re, sum_im;
        logic signed [MW-1:0] step_re, step_im;
        logic signed [CW-1:0] t_re, t_im;

        assign sum_re  = acc_re + AW'(term_re[k]);
        assign sum_im  = acc_im + AW'(term_im[k]);
        assign step_re = (MW'(sum_re) * MW'($signed({1'b0, mu}))) >>> (MUW + BLK_LOG2);
        assign step_im = (MW'(sum_im) * MW'($signed({1'b0, mu}))) >>> (MUW + BLK_LOG2);

        // Accumulate terms; on the block's last term step the tap and restart.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_re <= '0;
                acc_im <= '0;
                t_re   <= (k == CTR) ? ONE_C : '0;
                t_im   <= '0;
            end else if (clr) begin
                acc_re <= '0;
                acc_im <= '0;
            end else if (fire) begin
                acc_re <= '0;
                acc_im <= '0;
                t_re   <= satc(MW'(t_re) - step_re);
                t_im   <= satc(MW'(t_im) - step_im);
            end else if (acc_en) begin
                acc_re <= sum_re;
                acc_im <= sum_im;
            end
        end

        assign tap_re[k] = t_re;
        assign tap_im[k] = t_im;
    end

endmodule

// File: rtl/adapt_eq.sv
// Top of the block-normalised adaptive equaliser: symbol history, mode control,
// FIR, gradient and tap update, registered output.
// Assumes: one symbol per in_vld; pil_* is aligned with the output it references.
module adapt_eq import eqz_pkg::*; #(
    parameter int NTAP     = 5,
    parameter int DW       = 16,
    parameter int DFRAC    = 12,
    parameter int CW       = 20,
    parameter int CFRAC    = 16,
    parameter int MUW      = 8,
    parameter int BLK_LOG2 = 3,
    parameter int EPS      = 65536
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    input  logic                 pil_vld,
    input  logic signed [DW-1:0] pil_re,
    input  logic signed [DW-1:0] pil_im,
    input  logic [1:0]           mode,
    input  logic [MUW-1:0]       mu,
    output logic                 out_vld,
    output logic signed [DW-1:0] out_re,
    output logic signed [DW-1:0] out_im
);
    localparam int CTR = NTAP / 2;
    localparam int ERW = DW + 2;
    localparam int PW  = DW + ERW + 1;
    localparam int GW  = PW + CFRAC + 1;

    eq_mode_e             cur_mode;
    logic [1:0]           mode_q;
    logic                 passthru, clr, acc_en;
    logic signed [DW-1:0] hist_re [NTAP-1], hist_im [NTAP-1];
    logic signed [DW-1:0] win_re [NTAP], win_im [NTAP];
    logic signed [CW-1:0] tap_re [NTAP], tap_im [NTAP];
    logic signed [GW-1:0] term_re [NTAP], term_im [NTAP];
    logic signed [DW-1:0] y_re, y_im, ctr_re, ctr_im;
    logic [2*NTAP*CW-1:0] tap_flat;

    assign cur_mode = eq_mode_e'(mode);
    assign passthru = (cur_mode == MODE_BYPASS) || (cur_mode == MODE_RSVD);
    assign clr      = passthru || (mode != mode_q);
    assign acc_en   = in_vld && ((cur_mode == MODE_BLIND) ||
                                 ((cur_mode == MODE_PILOT) && pil_vld));

    assign win_re[0] = in_re;
    assign win_im[0] = in_im;
    for (genvar k = 1; k < NTAP; k++) begin : g_win
        assign win_re[k] = hist_re[k-1];
        assign win_im[k] = hist_im[k-1];
    end
    for (genvar k = 0; k < NTAP; k++) begin : g_flat
        assign tap_flat[k*CW +: CW]        = tap_re[k];
        assign tap_flat[(NTAP+k)*CW +: CW] = tap_im[k];
    end
    assign ctr_re = win_re[CTR];
    assign ctr_im = win_im[CTR];

    // Shift the symbol history on every valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NTAP-1; i++) begin
                hist_re[i] <= '0;
                hist_im[i] <= '0;
            end
        end else if (in_vld) begin
            hist_re[0] <= in_re;
            hist_im[0] <= in_im;
            for (int i = 1; i < NTAP-1; i++) begin
                hist_re[i] <= hist_re[i-1];
                hist_im[i] <= hist_im[i-1];
            end
        end
    end

    // Remember last cycle's mode to detect changes.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_BYPASS;
        else        mode_q <= mode;
    end

    eqz_fir #(.NT(NTAP), .DW(DW), .CW(CW), .CFRAC(CFRAC)) u_fir (
        .win_re(win_re), .win_im(win_im), .tap_re(tap_re), .tap_im(tap_im),
        .y_re(y_re), .y_im(y_im)
    );

    eqz_grad #(.NT(NTAP), .DW(DW), .DFRAC(DFRAC), .CFRAC(CFRAC), .EPS(EPS),
               .ERW(ERW), .GW(GW)) u_grad (
        .blind(cur_mode == MODE_BLIND), .y_re(y_re), .y_im(y_im),
        .ref_re(pil_re), .ref_im(pil_im), .win_re(win_re), .win_im(win_im),
        .term_re(term_re), .term_im(term_im)
    );

    eqz_taps #(.NT(NTAP), .CW(CW), .CFRAC(CFRAC), .GW(GW), .MUW(MUW),
               .BLK_LOG2(BLK_LOG2)) u_taps (
        .clk(clk), .rst_n(rst_n), .clr(clr), .acc_en(acc_en), .mu(mu),
        .term_re(term_re), .term_im(term_im), .tap_re(tap_re), .tap_im(tap_im)
    );

    // Register the equalised or passed-through symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_re  <= '0;
            out_im  <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_re <= passthru ? ctr_re : y_re;
                out_im <= passthru ? ctr_im : y_im;
            end
        end
    end

endmodule

// File: rtl/eqz_chk.sv
// Property checker for adapt_eq, attached by bind.
// Assumes: mode codes 0 and 3 mean pass-through.
module eqz_chk #(
    parameter int DW  = 16,
    parameter int MUW = 8,
    parameter int TW  = 200
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_vld,
    input logic [1:0]           mode,
    input logic [MUW-1:0]       mu,
    input logic                 out_vld,
    input logic signed [DW-1:0] out_re,
    input logic signed [DW-1:0] out_im,
    input logic signed [DW-1:0] ctr_re,
    input logic signed [DW-1:0] ctr_im,
    input logic [TW-1:0]        tap_flat
);
    logic pass;
    assign pass = (mode == 2'd0) || (mode == 2'd3);

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> (!out_vld && $stable(out_re) && $stable(out_im)));

    p_passthru_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && pass) |=> (out_re == $past(ctr_re) && out_im == $past(ctr_im)));

    p_frozen_taps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pass |=> $stable(tap_flat));

    p_step_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !pass) |-> (mu != '0));

endmodule

bind adapt_eq eqz_chk #(.DW(DW), .MUW(MUW), .TW(2*NTAP*CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .mode(mode), .mu(mu),
    .out_vld(out_vld), .out_re(out_re), .out_im(out_im),
    .ctr_re(ctr_re), .ctr_im(ctr_im), .tap_flat(tap_flat)
);

// File: tb/sim_adapt_eq.sv
// Bench for adapt_eq: directed corner cases plus seeded random QPSK through a 3-tap channel.
module sim_adapt_eq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0, pil_vld = 1'b0;
    logic signed [15:0] in_re = '0, in_im = '0, pil_re = '0, pil_im = '0;
    logic [1:0] mode = 2'd0;
    logic [7:0] mu = 8'd64;
    logic out_vld;
    logic signed [15:0] out_re, out_im;

    int total = 0, bad = 0;
    bit done = 1'b0;
    int xh_re [2], xh_im [2];
    int d_re, d_im, g_re, g_im;
    bit g_vld;
    int sh_re [4], sh_im [4];

    always #10 clk = ~clk;

    adapt_eq u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_re(in_re), .in_im(in_im),
        .pil_vld(pil_vld), .pil_re(pil_re), .pil_im(pil_im), .mode(mode), .mu(mu),
        .out_vld(out_vld), .out_re(out_re), .out_im(out_im)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one symbol, return the output and the input from two valid symbols back.
    task automatic send(input int re, input int im, input bit pv, input int pr, input int pi);
        @(negedge clk);
        in_vld = 1'b1; in_re = 16'(re); in_im = 16'(im);
        pil_vld = pv; pil_re = 16'(pr); pil_im = 16'(pi);
        @(negedge clk);
        in_vld = 1'b0; pil_vld = 1'b0;
        g_vld = out_vld; g_re = out_re; g_im = out_im;
        d_re = xh_re[1]; d_im = xh_im[1];
        xh_re[1] = xh_re[0]; xh_im[1] = xh_im[0];
        xh_re[0] = re; xh_im[0] = im;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode = m;
        @(negedge clk);
    endtask

    function automatic int qc();
        return ($urandom & 1) ? 2896 : -2896;
    endfunction

    function automatic int rnd16();
        return int'($signed(16'($urandom)));
    endfunction

    // Advance the channel: r_n = 0.2 s_{n+1} + s_n + 0.15 s_{n-1}, reference s_{n-2}.
    task automatic chan(output int r_re, output int r_im, output int p_re, output int p_im);
        for (int i = 3; i > 0; i--) begin
            sh_re[i] = sh_re[i-1]; sh_im[i] = sh_im[i-1];
        end
        sh_re[0] = qc(); sh_im[0] = qc();
        r_re = (819*sh_re[0] + 4096*sh_re[1] + 614*sh_re[2]) >>> 12;
        r_im = (819*sh_im[0] + 4096*sh_im[1] + 614*sh_im[2]) >>> 12;
        p_re = sh_re[3]; p_im = sh_im[3];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int rr, ri, pr, pi, last;
        real disp_early, disp_late, mse, yr, yi, er, ei;
        void'($urandom(32'd2024));
        xh_re = '{0, 0}; xh_im = '{0, 0};
        sh_re = '{0, 0, 0, 0}; sh_im = '{0, 0, 0, 0};
        repeat (4) @(negedge clk);
        check(out_vld == 1'b0, "R1 reset valid", int'(out_vld), 0);
        check(out_re == 0 && out_im == 0, "R1 reset output", int'(out_re), 0);
        rst_n = 1'b1;

        // R4: pass-through with full-scale random samples, also R2 valid timing.
        for (int n = 0; n < 40; n++) begin
            send(rnd16(), rnd16(), 1'b0, 0, 0);
            check(g_vld == 1'b1, "R2 valid follows input", int'(g_vld), 1);
            check(g_re == d_re && g_im == d_im, "R4 pass-through delay", g_re, d_re);
        end
        last = g_re;
        @(negedge clk);
        check(out_vld == 1'b0, "R2 valid low when idle", int'(out_vld), 0);
        check(out_re == 16'(last), "R2 output held", int'(out_re), last);
        send(rnd16(), rnd16(), 1'b1, rnd16(), rnd16());
        set_mode(2'd3);
        send(rnd16(), rnd16(), 1'b0, 0, 0);
        check(g_re == d_re && g_im == d_im, "R4 reserved code passes through", g_re, d_re);

        // R3/R1: blind, one short of a block: reset taps give exact delay.
        set_mode(2'd1);
        for (int n = 0; n < 7; n++) begin
            chan(rr, ri, pr, pi);
            send(rr, ri, 1'b0, 0, 0);
            check(g_re == d_re && g_im == d_im, "R3 spike taps exact FIR", g_re, d_re);
        end
        // R7: switch to pilot; partial blind block must be dropped.
        set_mode(2'd2);
        for (int n = 0; n < 7; n++) begin
            send(rnd16() / 4, rnd16() / 4, 1'b1, rnd16(), rnd16());
            check(g_re == d_re && g_im == d_im, "R7 partial block discarded", g_re, d_re);
        end
        // R6: non-pilot symbols with random references never update.
        for (int n = 0; n < 30; n++) begin
            send(rnd16() / 4, rnd16() / 4, 1'b0, rnd16(), rnd16());
            check(g_re == d_re && g_im == d_im, "R6 non-pilot ignored", g_re, d_re);
        end

        // R5: fresh blind block; L outputs on old taps, then a change.
        set_mode(2'd0);
        set_mode(2'd1);
        disp_early = 0.0;
        disp_late = 0.0;
        for (int n = 0; n < 3000; n++) begin
            chan(rr, ri, pr, pi);
            send(rr, ri, 1'b0, 0, 0);
            if (n < 8)
                check(g_re == d_re && g_im == d_im, "R5 taps held through block", g_re, d_re);
            if (n == 8)
                check(g_re != d_re || g_im != d_im, "R5 update after L symbols", g_re, d_re);
            yr = $itor(g_re) / 4096.0;
            yi = $itor(g_im) / 4096.0;
            if (n >= 2 && n < 66) disp_early += ((yr*yr + yi*yi - 1.0) < 0.0 ?
                                    -(yr*yr + yi*yi - 1.0) : (yr*yr + yi*yi - 1.0)) / 64.0;
            if (n >= 2488) disp_late += ((yr*yr + yi*yi - 1.0) < 0.0 ?
                                    -(yr*yr + yi*yi - 1.0) : (yr*yr + yi*yi - 1.0)) / 512.0;
        end
        check(disp_late < 0.5 * disp_early, "R11 blind dispersion reduced",
              int'(disp_late * 1e4), int'(0.5 * disp_early * 1e4));

        // R10: pilot-mode training with aligned reference.
        set_mode(2'd2);
        mse = 0.0;
        for (int n = 0; n < 4000; n++) begin
            chan(rr, ri, pr, pi);
            send(rr, ri, 1'b1, pr, pi);
            if (n >= 3488) begin
                er = $itor(g_re - pr) / 4096.0;
                ei = $itor(g_im - pi) / 4096.0;
                mse += (er*er + ei*ei) / 512.0;
            end
        end
        check(mse < 0.02, "R10 pilot error power below limit", int'(mse * 1e4), 200);
        check(mse < 0.0625, "R8 normalised update converges", int'(mse * 1e4), 625);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule